// File: doc/BRIEF.md
# PC Card Read Cycle Sequencer

This block runs one read cycle at a time toward a PC Card slot, in step with the host bus clock. A host request carries a card address, a space code (attribute memory, common memory or I/O) and two byte enables. The sequencer latches the request and drives the card address, the active-low card enables, the register-space select, the data direction and the address and data buffer enables. It then waits out a pre-charge phase, pulses either the memory read strobe or the I/O read strobe, and waits out a hold phase. Finally it returns the captured read data with a one-cycle done pulse.

Each of the three spaces has its own pre-charge, access and hold counts, supplied on configuration inputs and latched when a request is accepted. The card can stretch the strobe with its active-low wait line. The line passes through a two-flop synchronizer, and it only counts if it is seen early enough in the access phase.

The request side is valid/ready. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no cycle is running, so back-pressure lasts for the whole cycle. The host keeps its request fields steady until the transfer. The response side has no back-pressure: `done` is a one-cycle pulse and `rd_data` is valid with it.

Top module: `pccard_read_seq`

## Requirements
- R1: During and after reset, the idle outputs are as follows: `req_ready`=1, `done`=0, both strobes high, `card_ce_n`=2'b11, `card_reg_n`=1, `card_dir`=1, and both buffer enables high. An asynchronous reset in mid-cycle returns these values at once.
- R2: A request is accepted on a rising edge with `req_valid` and `req_ready` high. `req_ready` is then low from the next cycle until the done cycle. Requests presented while busy have no effect on the running cycle.
- R3: Space codes are 0 for attribute, 1 for common, 2 for I/O, and 3, which is handled as common. I/O cycles pulse `card_iord_n`, and the other spaces pulse `card_oe_n`. The unused strobe stays high for the whole cycle.
- R4: `card_reg_n` is low during attribute and I/O cycles and high during common cycles.
- R5: After acceptance, exactly P+1 cycles pass with the address and enables driven and the strobe high, where P is the selected space's pre-charge count.
- R6: With no wait, the strobe is low for exactly A+1 cycles, where A is the selected space's access count.
- R7: Wait is synchronized by two flops. It is honoured only if the synchronized wait is asserted in an access cycle that has at least 2 programmed access cycles still to follow. Once honoured, the strobe stays low until the synchronized wait is released. In bench terms: if `card_wait_n` goes low in access cycle j (counted from 0) and stays low for L cycles, the strobe width is max(A+1, j+L+3) when j ≤ A-4, and A+1 otherwise.
- R8: After the strobe rises, exactly H+1 hold cycles pass before the done cycle, where H is the selected space's hold count.
- R9: `rd_data` is the value of `card_data` at the rising edge where the strobe deasserts. Later changes of `card_data` do not affect it.
- R10: From the first pre-charge cycle to the last hold cycle, `card_addr`, `card_ce_n` (the inverse of the byte enables), `card_reg_n`, `card_dir`=0 and the buffer enables held low are all stable. They return to idle values in the done cycle.
- R11: `done` is high for exactly one cycle, with `rd_data` valid, and is followed by a low cycle.
- R12: The counts are taken from the selected space's fields at acceptance. Changes to the configuration inputs after acceptance, and the fields of other spaces, have no effect on the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_addr | input | ADDR_W | Card address of the request |
| req_space | input | 2 | Space code: 0 attribute, 1 common, 2 I/O |
| req_be | input | 2 | Byte enables, active high |
| cfg_pre | input | 3*CNT_W | Pre-charge counts, slot s at bits [s*CNT_W +: CNT_W] |
| cfg_acc | input | 3*CNT_W | Access counts, same slot layout |
| cfg_hold | input | 3*CNT_W | Hold counts, same slot layout |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |
| card_addr | output | ADDR_W | Card address |
| card_ce_n | output | 2 | Card byte enables, active low |
| card_reg_n | output | 1 | Register-space select, active low |
| card_oe_n | output | 1 | Memory read strobe, active low |
| card_iord_n | output | 1 | I/O read strobe, active low |
| card_dir | output | 1 | Data buffer direction, 0 = toward host |
| card_addr_oe_n | output | 1 | Address buffer enable, active low |
| card_data_oe_n | output | 1 | Data buffer enable, active low |
| card_wait_n | input | 1 | Card wait, active low, asynchronous |
| card_data | input | DATA_W | Card read data |

## Verification
Every result is due a fixed number of cycles after acceptance. The strobe falls after P+1 cycles, it rises A+1 cycles later (or at the R7 stretch point), and `done` rises H+1 cycles after that. The stretch point comes two cycles after `card_wait_n` changes, because of the synchronizer. The bench drives inputs on falling edges and samples every output on falling edges. It counts whole cycles per phase, so each phase length is compared exactly, with no tolerance. Wait vectors sit on both sides of the 2-cycle window, and `card_data` is left invalid except while the strobe is low, so that late capture is exposed.

// File: rtl/pccard_rd_pkg.sv
package pccard_rd_pkg;
  parameter int unsigned CNT_W  = 8;
  parameter int unsigned N_SPC  = 3;

  typedef enum logic [1:0] {
    SP_ATTR = 2'd0,
    SP_COMM = 2'd1,
    SP_IO   = 2'd2,
    SP_RSVD = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_ACC  = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] pre;
    logic [CNT_W-1:0] acc;
    logic [CNT_W-1:0] hold;
  } timing_t;
endpackage

// File: rtl/pccard_sync2.sv
module pccard_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;
endmodule

// File: rtl/pccard_timing_sel.sv
module pccard_timing_sel
  import pccard_rd_pkg::*;
(
  input  logic [N_SPC*CNT_W-1:0] cfg_pre,
  input  logic [N_SPC*CNT_W-1:0] cfg_acc,
  input  logic [N_SPC*CNT_W-1:0] cfg_hold,
  input  space_e                 space,
  output timing_t                t_sel
);
  timing_t slot [N_SPC];

  for (genvar g = 0; g < N_SPC; g++) begin : g_slot
    assign slot[g].pre  = cfg_pre [g*CNT_W +: CNT_W];
    assign slot[g].acc  = cfg_acc [g*CNT_W +: CNT_W];
    assign slot[g].hold = cfg_hold[g*CNT_W +: CNT_W];
  end

  always_comb begin
    unique case (space)
      SP_ATTR: t_sel = slot[0];
      SP_IO:   t_sel = slot[2];
      default: t_sel = slot[1];
    endcase
  end
endmodule

// File: rtl/pccard_rd_fsm.sv
module pccard_rd_fsm
  import pccard_rd_pkg::*;
#(
  parameter int unsigned WAIT_LEAD = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  timing_t t_in,
  input  logic    wait_act,
  output phase_e  phase,
  output logic    strobe_end,
  output logic    cycle_end
);
  localparam logic [CNT_W-1:0] LEAD = CNT_W'(WAIT_LEAD);

  phase_e           ph_q;
  timing_t          tim_q;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             stretch;

  assign stretch    = armed_q && wait_act;
  assign strobe_end = (ph_q == PH_ACC) && (cnt_q == '0) && !stretch;
  assign cycle_end  = (ph_q == PH_HOLD) && (cnt_q == '0);
  assign phase      = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      tim_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          armed_q <= 1'b0;
          if (start) begin
            tim_q <= t_in;
            cnt_q <= t_in.pre;
            ph_q  <= PH_PRE;
          end
        end
        PH_PRE: begin
          if (cnt_q == '0) begin
            cnt_q <= tim_q.acc;
            ph_q  <= PH_ACC;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_ACC: begin
          if (wait_act && (cnt_q >= LEAD)) armed_q <= 1'b1;
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!stretch) begin
            cnt_q   <= tim_q.hold;
            armed_q <= 1'b0;
            ph_q    <= PH_HOLD;
          end
        end
        PH_HOLD: begin
          if (cnt_q == '0) ph_q <= PH_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R6: a strobe phase with access cycles left cannot end early
  assert_acc_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ACC && cnt_q != '0) |=> ph_q == PH_ACC);

  // R7: a wait seen inside the last two access cycles never arms the stretch
  assert_late_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ACC && cnt_q < LEAD && !armed_q) |=> !armed_q);

  // R8: hold phase lasts until its count is used up
  assert_hold_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_HOLD && cnt_q != '0) |=> ph_q == PH_HOLD);

  // R5: pre-charge always flows into the access phase
  assert_pre_to_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PRE && cnt_q == '0) |=> ph_q == PH_ACC);
endmodule

// File: rtl/pccard_read_seq.sv
module pccard_read_seq
  import pccard_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_space,
  input  logic [1:0]             req_be,
  input  logic [N_SPC*CNT_W-1:0] cfg_pre,
  input  logic [N_SPC*CNT_W-1:0] cfg_acc,
  input  logic [N_SPC*CNT_W-1:0] cfg_hold,
  output logic                   done,
  output logic [DATA_W-1:0]      rd_data,
  output logic [ADDR_W-1:0]      card_addr,
  output logic [1:0]             card_ce_n,
  output logic                   card_reg_n,
  output logic                   card_oe_n,
  output logic                   card_iord_n,
  output logic                   card_dir,
  output logic                   card_addr_oe_n,
  output logic                   card_data_oe_n,
  input  logic                   card_wait_n,
  input  logic [DATA_W-1:0]      card_data
);
  space_e            sp_in;
  timing_t           t_sel;
  phase_e            phase;
  logic              accept, strobe_end, cycle_end;
  logic              wait_n_s, busy, strobing;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        be_q;
  logic              io_q, reg_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q;

  assign sp_in  = space_e'(req_space);
  assign busy   = (phase != PH_IDLE);
  assign accept = req_valid && req_ready;

  pccard_timing_sel u_tsel (
    .cfg_pre  (cfg_pre),
    .cfg_acc  (cfg_acc),
    .cfg_hold (cfg_hold),
    .space    (sp_in),
    .t_sel    (t_sel)
  );

  pccard_sync2 #(.RST_VAL(1'b1)) u_wsync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (card_wait_n),
    .q_sync  (wait_n_s)
  );

  pccard_rd_fsm #(.WAIT_LEAD(2)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .t_in       (t_sel),
    .wait_act   (!wait_n_s),
    .phase      (phase),
    .strobe_end (strobe_end),
    .cycle_end  (cycle_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      be_q   <= '0;
      io_q   <= 1'b0;
      reg_q  <= 1'b0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q <= req_addr;
        be_q   <= req_be;
        io_q   <= (sp_in == SP_IO);
        reg_q  <= (sp_in == SP_ATTR) || (sp_in == SP_IO);
      end
      if (strobe_end) data_q <= card_data;
      done_q <= cycle_end;
    end
  end

  assign strobing       = (phase == PH_ACC);
  assign req_ready      = !busy;
  assign done           = done_q;
  assign rd_data        = data_q;
  assign card_addr      = addr_q;
  assign card_ce_n      = busy ? ~be_q : 2'b11;
  assign card_reg_n     = busy ? !reg_q : 1'b1;
  assign card_oe_n      = !(strobing && !io_q);
  assign card_iord_n    = !(strobing && io_q);
  assign card_dir       = !busy;
  assign card_addr_oe_n = !busy;
  assign card_data_oe_n = !busy;

  // R3: never both strobes at once
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!card_oe_n && !card_iord_n));

  // R2: an accepted request drops ready on the next cycle
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10: card controls hold steady while a cycle runs
  assert_ctrl_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(card_addr) && $stable(card_ce_n) && $stable(card_reg_n)));

  // R10: a strobe is only driven with the buffers enabled inbound
  assert_strobe_buffers_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_oe_n || !card_iord_n) |-> (!card_addr_oe_n && !card_data_oe_n && !card_dir));

  // R11: done is a single-cycle pulse
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: done only arrives after a hold phase
  assert_done_after_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(phase) == PH_HOLD);
endmodule

// File: tb/tb_pccard_read_seq.sv
`timescale 1ns/1ps
module tb_pccard_read_seq;
  localparam int AW = 26;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_space = 2'd0;
  logic [1:0] req_be = 2'b00;
  logic [23:0] cfg_pre = '0, cfg_acc = '0, cfg_hold = '0;
  logic done;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] card_addr;
  logic [1:0] card_ce_n;
  logic card_reg_n, card_oe_n, card_iord_n, card_dir, card_addr_oe_n, card_data_oe_n;
  logic card_wait_n = 1'b1;
  logic [DW-1:0] card_data = '0;

  always #2.5 clk = ~clk;

  pccard_read_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_space(req_space), .req_be(req_be),
    .cfg_pre(cfg_pre), .cfg_acc(cfg_acc), .cfg_hold(cfg_hold),
    .done(done), .rd_data(rd_data), .card_addr(card_addr), .card_ce_n(card_ce_n),
    .card_reg_n(card_reg_n), .card_oe_n(card_oe_n), .card_iord_n(card_iord_n),
    .card_dir(card_dir), .card_addr_oe_n(card_addr_oe_n), .card_data_oe_n(card_data_oe_n),
    .card_wait_n(card_wait_n), .card_data(card_data)
  );

  typedef struct packed {
    logic [1:0]    sp;
    logic [7:0]    p, a, h;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [1:0]    be;
    logic [7:0]    wj;   // 8'hFF: no wait
    logic [7:0]    wl;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{2'd0, 8'd0, 8'd0, 8'd0, 26'h0000100, 16'hA5C3, 2'b11, 8'hFF, 8'd0},
    '{2'd1, 8'd2, 8'd3, 8'd1, 26'h0001234, 16'h0F0F, 2'b01, 8'hFF, 8'd0},
    '{2'd2, 8'd1, 8'd2, 8'd4, 26'h00003F0, 16'h8001, 2'b10, 8'hFF, 8'd0},
    '{2'd1, 8'd3, 8'd6, 8'd2, 26'h2ABCDE0, 16'h1357, 2'b11, 8'd1,  8'd10},
    '{2'd0, 8'd0, 8'd6, 8'd0, 26'h0000042, 16'h2468, 2'b01, 8'd2,  8'd10},
    '{2'd2, 8'd1, 8'd6, 8'd1, 26'h0000080, 16'hBEEF, 2'b11, 8'd3,  8'd10},
    '{2'd1, 8'd0, 8'd6, 8'd3, 26'h3FFFFFF, 16'hC0DE, 2'b10, 8'd4,  8'd3},
    '{2'd2, 8'd5, 8'd9, 8'd2, 26'h0000155, 16'h7E57, 2'b01, 8'd0,  8'd2},
    '{2'd3, 8'd1, 8'd1, 8'd1, 26'h0000200, 16'h55AA, 2'b11, 8'hFF, 8'd0}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_acc(input int a, input int j, input int l);
    int w;
    if (j == 255 || j + 4 > a) return a + 1;
    w = j + l + 3;
    return (w > a + 1) ? w : a + 1;
  endfunction

  task automatic check_idle(input string req);
    chk(req_ready === 1'b1, req, "req_ready idle", req_ready, 1);
    chk(done === 1'b0, req, "done idle", done, 0);
    chk({card_oe_n, card_iord_n} === 2'b11, req, "strobes idle", {card_oe_n, card_iord_n}, 3);
    chk(card_ce_n === 2'b11, req, "card_ce_n idle", card_ce_n, 3);
    chk({card_reg_n, card_dir, card_addr_oe_n, card_data_oe_n} === 4'hF, req,
        "reg/dir/buffers idle", {card_reg_n, card_dir, card_addr_oe_n, card_data_oe_n}, 15);
  endtask

  task automatic set_cfg(input vec_t v);
    for (int s = 0; s < 3; s++) begin
      bit hit = (s == int'(v.sp)) || (v.sp == 2'd3 && s == 1);
      cfg_pre [s*8 +: 8] = hit ? v.p : 8'd9;
      cfg_acc [s*8 +: 8] = hit ? v.a : 8'd13;
      cfg_hold[s*8 +: 8] = hit ? v.h : 8'd7;
    end
  endtask

  task automatic run_vec(input vec_t v);
    int pre_n = 0, acc_n = 0, hold_n = 0, ph = 0, wc = 0, guard = 0;
    bit wact = 0, bad_rdy = 0, bad_ctl = 0, bad_stb = 0, got_done = 0;
    bit is_io = (v.sp == 2'd2);
    bit exp_reg_n = (v.sp == 2'd1) || (v.sp == 2'd3);
    set_cfg(v);
    card_data = ~v.data;
    card_wait_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_addr = v.addr; req_space = v.sp; req_be = v.be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~v.addr; req_space = 2'd0; req_be = ~v.be;
    cfg_pre = 24'hFFFFFF; cfg_acc = 24'hFFFFFF; cfg_hold = 24'hFFFFFF; // R12: late changes
    while (guard < 2000) begin
      guard++;
      if (wact) begin
        wc++;
        if (wc == int'(v.wl)) begin card_wait_n = 1'b1; wact = 0; end
      end
      if (done === 1'b1) begin got_done = 1; break; end
      if (req_ready !== 1'b0) bad_rdy = 1;
      if (card_addr !== v.addr || card_ce_n !== ~v.be || card_reg_n !== exp_reg_n ||
          card_dir !== 1'b0 || card_addr_oe_n !== 1'b0 || card_data_oe_n !== 1'b0)
        bad_ctl = 1;
      if (card_oe_n === 1'b0 || card_iord_n === 1'b0) begin
        if (ph == 2) bad_stb = 1;
        ph = 1;
        if (is_io ? (card_oe_n !== 1'b1) : (card_iord_n !== 1'b1)) bad_stb = 1;
        card_data = v.data;
        if (v.wj != 8'hFF && acc_n == int'(v.wj)) begin
          card_wait_n = 1'b0; wact = 1; wc = 0;
        end
        acc_n++;
      end else if (ph == 0) begin
        pre_n++;
      end else begin
        ph = 2;
        hold_n++;
        card_data = ~v.data;
      end
      @(negedge clk);
    end
    card_wait_n = 1'b1;
    chk(got_done, "R11", "done seen", got_done, 1);
    chk(!bad_rdy, "R2", "ready low while busy", bad_rdy, 0);
    chk(!bad_stb, "R3", "strobe select", bad_stb, 0);
    chk(!bad_ctl, "R10/R4", "controls held", bad_ctl, 0);
    chk(pre_n == int'(v.p) + 1, "R5/R12", "pre-charge cycles", pre_n, int'(v.p) + 1);
    chk(acc_n == exp_acc(int'(v.a), int'(v.wj), int'(v.wl)),
        (v.wj == 8'hFF) ? "R6/R12" : "R7", "strobe cycles",
        acc_n, exp_acc(int'(v.a), int'(v.wj), int'(v.wl)));
    chk(hold_n == int'(v.h) + 1, "R8/R12", "hold cycles", hold_n, int'(v.h) + 1);
    chk(rd_data === v.data, "R9", "read data", rd_data, v.data);
    chk(card_ce_n === 2'b11 && card_dir === 1'b1 && card_addr_oe_n === 1'b1,
        "R10", "released in done cycle", {card_ce_n, card_dir, card_addr_oe_n}, 5'h0F);
    @(negedge clk);
    chk(done === 1'b0, "R11", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    for (int i = 0; i < NV; i++) run_vec(VT[i]);

    // R2: request held high while busy has no effect on the running cycle
    begin
      vec_t v = '{2'd1, 8'd0, 8'd2, 8'd0, 26'h0000AAA, 16'h1111, 2'b11, 8'hFF, 8'd0};
      int dones = 0;
      bit addr_ok = 1;
      set_cfg(v);
      card_data = v.data;
      @(negedge clk);
      req_valid = 1'b1; req_addr = v.addr; req_space = 2'd1; req_be = 2'b11;
      @(posedge clk);
      @(negedge clk);
      req_addr = 26'h0000BBB;
      for (int c = 0; c < 6; c++) begin
        if (done === 1'b1) begin dones++; break; end
        if (card_addr !== v.addr) addr_ok = 0;
        @(negedge clk);
      end
      chk(dones == 1, "R2", "one done for first request", dones, 1);
      chk(addr_ok, "R2", "busy request ignored", addr_ok, 1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(card_addr === 26'h0000BBB, "R2", "next request accepted at done", card_addr, 26'hBBB);
      for (int c = 0; c < 10 && done !== 1'b1; c++) @(negedge clk);
      @(negedge clk);
    end

    // R1: reset in the middle of a strobe
    begin
      vec_t v = '{2'd2, 8'd0, 8'd20, 8'd0, 26'h0000123, 16'h4321, 2'b01, 8'hFF, 8'd0};
      set_cfg(v);
      @(negedge clk);
      req_valid = 1'b1; req_addr = v.addr; req_space = v.sp; req_be = v.be;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk(card_iord_n === 1'b0, "R3", "io strobe low before reset", card_iord_n, 0);
      rst_n = 1'b0;
      #1;
      check_idle("R1");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle("R1");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule